// File: doc/BRIEF.md
# Single-Wire Slave Bit-Slot Engine

This block is the timing front end of a slave on a single open-drain data line that idles high and that any attached device may only pull low. A bus master starts every exchange with a falling edge. The block samples the line with a known clock, given as a count of clocks per microsecond. It measures how long each low lasts, and from that it tells a bus reset from an ordinary time slot. After a reset it answers with a presence pulse. It decodes write slots into bits and answers read slots by holding the line low for a 0.

The upper layer does the byte framing. It sees a one-cycle strobe for each received bit and a one-cycle strobe for each bus reset. When it expects the master to read, it raises `tx_arm` with the bit to send on `tx_bit`. The engine consumes that bit at the next slot edge and acknowledges it with `tx_take`. Slots that arrive while `tx_arm` is low are handled as write slots.

Top module: `swire_slot_engine`

## Requirements
- R1: Out of synchronous reset, `line_pull` is 0 and `rx_valid`, `tx_take` and `reset_seen` are all 0.
- R2: A low on the line that lasts fewer than `GLITCH_CLKS` clocks causes no `rx_valid` and no `tx_take`, whatever the state of `tx_arm`.
- R3: A slot that starts while `tx_arm` is 0 produces exactly one `rx_valid` pulse of one cycle, 15 to 60 µs after the falling edge (nominally `SAMPLE_US` plus the input latency). `rx_bit` carries the line level at that moment: 1 for a master low of 1 to 15 µs, and 0 for a master low of 60 to 120 µs.
- R4: A slot that starts while `tx_arm` is 1 and `tx_bit` is 0 asserts `line_pull` in the same cycle as `tx_take`. The pull lasts `HOLD_US`, so the line reads low until at least 15 µs after the edge and is released before 45 µs.
- R5: A slot that starts while `tx_arm` is 1 and `tx_bit` is 1 leaves `line_pull` at 0 for the whole slot.
- R6: Every slot that starts while `tx_arm` is 1 gives exactly one one-cycle `tx_take` pulse. Such a slot gives no `rx_valid`, and the two strobes are never high together.
- R7: A low of at least `RESET_US` gives one one-cycle `reset_seen` pulse when the line rises. Shorter lows give none.
- R8: After `reset_seen`, `line_pull` stays 0 for the `PWAIT_US` wait (15 to 60 µs after the line rose). It then stays 1 for `PLOW_US` (within 60 to 240 µs). No pull ever lasts longer than the longest of `HOLD_US` and `PLOW_US`.
- R9: The falling edge that the block's own presence pulse makes on the line is not taken as a slot: it produces no `tx_take` and no `rx_valid`, even while `tx_arm` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, `CLK_PER_US` cycles per microsecond |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw level of the shared data line (asynchronous) |
| line_pull | output | 1 | 1 turns on the open-drain pull-down of the line |
| rx_valid | output | 1 | One-cycle strobe: a write-slot bit was sampled |
| rx_bit | output | 1 | Value of the sampled bit, valid with `rx_valid` |
| tx_arm | input | 1 | The next slot is a read slot; send `tx_bit` |
| tx_bit | input | 1 | Bit to send in the next armed slot |
| tx_take | output | 1 | One-cycle strobe: an armed slot started and `tx_bit` was consumed |
| reset_seen | output | 1 | One-cycle strobe: a bus reset ended and presence begins |

## Verification
The assertions check a set of rules on every cycle. Each strobe lasts one cycle, and `rx_valid` and `tx_take` never coincide. The pull state at a `tx_take` matches the bit that was consumed. No pull is active when a reset is reported, and no pull runs past its longest allowed length. Only the bench scenarios can show the time-domain behaviour. This covers the distance from the master's edge to the sample point, the decoded value across a sweep of master low lengths, and the reset threshold on either side of `RESET_US`. It also covers the placement of the presence pulse after the line rises and the fact that glitches and the block's own presence edge are ignored.

// File: rtl/swire_pkg.sv
package swire_pkg;

    // Filtered view of the data line: settled level plus edge strobes.
    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } line_evt_t;

    typedef enum logic [2:0] {
        ST_IDLE,    // line high, waiting for a master edge
        ST_LOW,     // line low, timing the low and sampling writes
        ST_HOLD,    // driving a read 0
        ST_PWAIT,   // gap between reset release and presence
        ST_PDRIVE,  // driving presence
        ST_SETTLE   // presence released, waiting for the line to rise
    } slot_state_e;

    function automatic int unsigned us_ticks(input int unsigned us,
                                             input int unsigned clk_per_us);
        return us * clk_per_us;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= 1'b1;
                    else     chain[gi] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= 1'b1;
                    else     chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/swire_deglitch.sv
module swire_deglitch
    import swire_pkg::*;
#(
    parameter int unsigned GLITCH_CLKS = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output line_evt_t evt
);
    localparam int unsigned CW = $clog2(GLITCH_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CLKS - 1);

    logic          level;
    logic          fall_q;
    logic          rise_q;
    logic [CW-1:0] run;

    // The level follows din only once din has differed for GLITCH_CLKS cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            level  <= 1'b1;
            fall_q <= 1'b0;
            rise_q <= 1'b0;
            run    <= '0;
        end else begin
            fall_q <= 1'b0;
            rise_q <= 1'b0;
            if (din != level) begin
                if (run == LAST) begin
                    level  <= din;
                    fall_q <= ~din;
                    rise_q <= din;
                    run    <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end else begin
                run <= '0;
            end
        end
    end

    assign evt.level = level;
    assign evt.fall  = fall_q;
    assign evt.rise  = rise_q;
endmodule

// File: rtl/swire_slot_fsm.sv
module swire_slot_fsm
    import swire_pkg::*;
#(
    parameter int unsigned SAMPLE_T = 1500,
    parameter int unsigned HOLD_T   = 1500,
    parameter int unsigned RESET_T  = 24000,
    parameter int unsigned PWAIT_T  = 1500,
    parameter int unsigned PLOW_T   = 6000
) (
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    input  logic      tx_arm,
    input  logic      tx_bit,
    output logic      line_pull,
    output logic      rx_valid,
    output logic      rx_bit,
    output logic      tx_take,
    output logic      reset_seen
);
    localparam int unsigned CNT_MAX =
        max2(max2(SAMPLE_T, HOLD_T), max2(RESET_T, max2(PWAIT_T, PLOW_T))) + 1;
    localparam int unsigned CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] C_FULL   = CW'(CNT_MAX);
    localparam logic [CW-1:0] C_SAMPLE = CW'(SAMPLE_T);
    localparam logic [CW-1:0] C_HOLD   = CW'(HOLD_T);
    localparam logic [CW-1:0] C_RESET  = CW'(RESET_T);
    localparam logic [CW-1:0] C_PWAIT  = CW'(PWAIT_T);
    localparam logic [CW-1:0] C_PLOW   = CW'(PLOW_T);

    slot_state_e   state;
    logic [CW-1:0] cnt;          // cycles since the last timing origin, saturating
    logic          sample_pend;  // write slot whose bit is still to be sampled

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            sample_pend <= 1'b0;
            line_pull   <= 1'b0;
            rx_valid    <= 1'b0;
            rx_bit      <= 1'b0;
            tx_take     <= 1'b0;
            reset_seen  <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            tx_take    <= 1'b0;
            reset_seen <= 1'b0;
            if (cnt != C_FULL) cnt <= cnt + 1'b1;

            unique case (state)
                ST_IDLE: begin
                    if (evt.fall) begin
                        cnt <= CW'(1);
                        if (tx_arm) begin
                            tx_take     <= 1'b1;
                            sample_pend <= 1'b0;
                            if (!tx_bit) begin
                                line_pull <= 1'b1;
                                state     <= ST_HOLD;
                            end else begin
                                state <= ST_LOW;
                            end
                        end else begin
                            sample_pend <= 1'b1;
                            state       <= ST_LOW;
                        end
                    end
                end
                ST_LOW: begin
                    if (sample_pend && cnt == C_SAMPLE) begin
                        rx_valid    <= 1'b1;
                        rx_bit      <= evt.level;
                        sample_pend <= 1'b0;
                    end else if (!sample_pend && evt.level) begin
                        if (cnt >= C_RESET) begin
                            reset_seen <= 1'b1;
                            cnt        <= CW'(1);
                            state      <= ST_PWAIT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (cnt == C_HOLD) begin
                        line_pull <= 1'b0;
                        state     <= ST_LOW;
                    end
                end
                ST_PWAIT: begin
                    if (cnt == C_PWAIT) begin
                        line_pull <= 1'b1;
                        cnt       <= CW'(1);
                        state     <= ST_PDRIVE;
                    end
                end
                ST_PDRIVE: begin
                    // Edges seen here are the block's own pull; they are not slots.
                    if (cnt == C_PLOW) begin
                        line_pull <= 1'b0;
                        state     <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (evt.level) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swire_slot_engine.sv
module swire_slot_engine
    import swire_pkg::*;
#(
    parameter int unsigned CLK_PER_US  = 50,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned GLITCH_CLKS = 5,
    parameter int unsigned SAMPLE_US   = 30,
    parameter int unsigned HOLD_US     = 30,
    parameter int unsigned RESET_US    = 480,
    parameter int unsigned PWAIT_US    = 30,
    parameter int unsigned PLOW_US     = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_pull,
    output logic rx_valid,
    output logic rx_bit,
    input  logic tx_arm,
    input  logic tx_bit,
    output logic tx_take,
    output logic reset_seen
);
    localparam int unsigned SAMPLE_T = us_ticks(SAMPLE_US, CLK_PER_US);
    localparam int unsigned HOLD_T   = us_ticks(HOLD_US,   CLK_PER_US);
    localparam int unsigned RESET_T  = us_ticks(RESET_US,  CLK_PER_US);
    localparam int unsigned PWAIT_T  = us_ticks(PWAIT_US,  CLK_PER_US);
    localparam int unsigned PLOW_T   = us_ticks(PLOW_US,   CLK_PER_US);

    logic      line_s;
    line_evt_t evt;

    swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (line_in),
        .dout(line_s)
    );

    swire_deglitch #(.GLITCH_CLKS(GLITCH_CLKS)) u_filt (
        .clk(clk),
        .rst(rst),
        .din(line_s),
        .evt(evt)
    );

    swire_slot_fsm #(
        .SAMPLE_T(SAMPLE_T),
        .HOLD_T  (HOLD_T),
        .RESET_T (RESET_T),
        .PWAIT_T (PWAIT_T),
        .PLOW_T  (PLOW_T)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .tx_arm    (tx_arm),
        .tx_bit    (tx_bit),
        .line_pull (line_pull),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .tx_take   (tx_take),
        .reset_seen(reset_seen)
    );
endmodule

// File: rtl/swire_slot_engine_chk.sv
module swire_slot_engine_chk #(
    parameter int unsigned CLK_PER_US = 50,
    parameter int unsigned HOLD_US    = 30,
    parameter int unsigned PLOW_US    = 120
) (
    input logic clk,
    input logic rst,
    input logic line_pull,
    input logic rx_valid,
    input logic tx_take,
    input logic tx_bit,
    input logic reset_seen
);
    localparam int unsigned MAX_PULL =
        ((HOLD_US > PLOW_US) ? HOLD_US : PLOW_US) * CLK_PER_US;

    int unsigned pull_run;

    always_ff @(posedge clk) begin
        if (rst) pull_run <= 0;
        else if (line_pull) pull_run <= pull_run + 1;
        else pull_run <= 0;
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            AST_PULL_BOUNDED: assert (pull_run <= MAX_PULL); // R8
            AST_RX_NOT_WITH_TAKE: assert (!(rx_valid && tx_take)); // R6
        end
    end

    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R3

    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> !tx_take); // R6

    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        reset_seen |=> !reset_seen); // R7

    AST_READ0_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (tx_take && !$past(tx_bit)) |-> line_pull); // R4

    AST_READ1_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tx_take && $past(tx_bit)) |-> !line_pull); // R5

    AST_RESET_NO_PULL: assert property (@(posedge clk) disable iff (rst)
        reset_seen |-> !line_pull); // R8

    AST_RESET_NOT_RX: assert property (@(posedge clk) disable iff (rst)
        reset_seen |-> !tx_take); // R9
endmodule

bind swire_slot_engine swire_slot_engine_chk #(
    .CLK_PER_US(CLK_PER_US),
    .HOLD_US   (HOLD_US),
    .PLOW_US   (PLOW_US)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_pull (line_pull),
    .rx_valid  (rx_valid),
    .tx_take   (tx_take),
    .tx_bit    (tx_bit),
    .reset_seen(reset_seen)
);

// File: tb/swire_slot_engine_test.sv
`timescale 1ns/1ps
module swire_slot_engine_test;
    localparam int CPU = 4;
    localparam int GL  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_low = 1'b0;
    logic tx_arm = 1'b0;
    logic tx_bit = 1'b1;
    logic line_pull, rx_valid, rx_bit, tx_take, reset_seen;
    logic bus;

    assign bus = ~(master_low | line_pull);

    always #10 clk = ~clk;

    swire_slot_engine #(.CLK_PER_US(CPU), .GLITCH_CLKS(GL)) uut (
        .clk(clk), .rst(rst), .line_in(bus), .line_pull(line_pull),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_arm(tx_arm), .tx_bit(tx_bit),
        .tx_take(tx_take), .reset_seen(reset_seen)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    int rx_cnt = 0, take_cnt = 0, rst_cnt = 0, pull_rises = 0;
    int last_rx_bit = 0, last_rx_cyc = 0;
    int pull_rise_cyc = 0, pull_len = 0;
    int bus_fall_cyc = 0, bus_low_len = 0;
    logic pull_d = 1'b0, bus_d = 1'b1;
    int t_fall = 0, t_rel = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (rx_valid) begin
                rx_cnt <= rx_cnt + 1;
                last_rx_bit <= int'(rx_bit);
                last_rx_cyc <= cyc;
            end
            if (tx_take) take_cnt <= take_cnt + 1;
            if (reset_seen) rst_cnt <= rst_cnt + 1;
            if (line_pull && !pull_d) begin
                pull_rises <= pull_rises + 1;
                pull_rise_cyc <= cyc;
            end
            if (!line_pull && pull_d) pull_len <= cyc - pull_rise_cyc;
            if (!bus && bus_d) bus_fall_cyc <= cyc;
            if (bus && !bus_d) bus_low_len <= cyc - bus_fall_cyc;
        end
        pull_d <= line_pull;
        bus_d <= bus;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Master pulls the line low for low_c cycles, then keeps it released
    // until total_c cycles after the edge.
    task automatic slot(input int low_c, input int total_c);
        @(negedge clk); #1;
        master_low = 1'b1;
        t_fall = cyc;
        wait_cyc(low_c);
        master_low = 1'b0;
        t_rel = cyc;
        wait_cyc(total_c - low_c);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rx0, tk0, rs0, pr0;
        wait_cyc(4);
        // R1: state out of reset
        chk(line_pull == 0 && rx_valid == 0 && tx_take == 0 && reset_seen == 0,
            "R1 idle outputs", int'({line_pull, rx_valid, tx_take, reset_seen}), 0);
        rst = 1'b0;
        wait_cyc(10 * CPU);

        // R3: write-1 sweep over master low lengths of 1..14 us
        for (int lo = 1; lo <= 14; lo++) begin
            rx0 = rx_cnt;
            slot(lo * CPU, 75 * CPU);
            chk(rx_cnt == rx0 + 1, "R3 write1 strobe count", rx_cnt - rx0, 1);
            chk(last_rx_bit == 1, "R3 write1 value", last_rx_bit, 1);
            chk(last_rx_cyc - t_fall >= 15 * CPU && last_rx_cyc - t_fall <= 60 * CPU,
                "R3 sample point", last_rx_cyc - t_fall, 30 * CPU);
        end

        // R3: write-0 sweep over 60..120 us
        for (int lo = 60; lo <= 120; lo += 10) begin
            rx0 = rx_cnt;
            slot(lo * CPU, (lo + 10) * CPU);
            chk(rx_cnt == rx0 + 1, "R3 write0 strobe count", rx_cnt - rx0, 1);
            chk(last_rx_bit == 0, "R3 write0 value", last_rx_bit, 0);
        end

        // R2: glitches shorter than the filter, armed and unarmed
        for (int g = 1; g < GL; g++) begin
            for (int a = 0; a < 2; a++) begin
                rx0 = rx_cnt; tk0 = take_cnt;
                tx_arm = a[0]; tx_bit = 1'b0;
                slot(g, 80 * CPU);
                tx_arm = 1'b0;
                chk(rx_cnt == rx0 && take_cnt == tk0, "R2 glitch ignored",
                    (rx_cnt - rx0) + (take_cnt - tk0), 0);
            end
        end

        // R4, R6: read slots sending 0
        for (int lo = 1; lo <= 10; lo++) begin
            rx0 = rx_cnt; tk0 = take_cnt;
            tx_arm = 1'b1; tx_bit = 1'b0;
            slot(lo * CPU, 80 * CPU);
            tx_arm = 1'b0;
            chk(take_cnt == tk0 + 1, "R6 take per armed slot", take_cnt - tk0, 1);
            chk(rx_cnt == rx0, "R6 no rx in armed slot", rx_cnt - rx0, 0);
            chk(bus_low_len >= 15 * CPU && bus_low_len < 45 * CPU,
                "R4 read0 low length", bus_low_len, 30 * CPU);
        end

        // R5, R6: read slots sending 1
        for (int lo = 1; lo <= 10; lo++) begin
            tk0 = take_cnt; pr0 = pull_rises;
            tx_arm = 1'b1; tx_bit = 1'b1;
            slot(lo * CPU, 80 * CPU);
            tx_arm = 1'b0;
            chk(take_cnt == tk0 + 1, "R6 take per armed slot", take_cnt - tk0, 1);
            chk(pull_rises == pr0, "R5 read1 no pull", pull_rises - pr0, 0);
        end

        // R7: lows just under the reset threshold
        for (int lo = 400; lo <= 470; lo += 70) begin
            rs0 = rst_cnt; pr0 = pull_rises;
            slot(lo * CPU, (lo + 300) * CPU);
            chk(rst_cnt == rs0, "R7 short low no reset", rst_cnt - rs0, 0);
            chk(pull_rises == pr0, "R8 no presence without reset", pull_rises - pr0, 0);
        end

        // R7, R8: resets and presence timing
        for (int lo = 490; lo <= 970; lo += 240) begin
            rs0 = rst_cnt; pr0 = pull_rises;
            slot(lo * CPU, (lo + 300) * CPU);
            chk(rst_cnt == rs0 + 1, "R7 reset detected", rst_cnt - rs0, 1);
            chk(pull_rises == pr0 + 1, "R8 one presence", pull_rises - pr0, 1);
            chk(pull_rise_cyc - t_rel >= 15 * CPU && pull_rise_cyc - t_rel <= 60 * CPU,
                "R8 presence wait", pull_rise_cyc - t_rel, 30 * CPU);
            chk(pull_len >= 60 * CPU && pull_len <= 240 * CPU,
                "R8 presence length", pull_len, 120 * CPU);
        end

        // R9: own presence edge with tx_arm high is not a slot
        @(negedge clk); #1;
        master_low = 1'b1;
        wait_cyc(500 * CPU);
        master_low = 1'b0;
        rx0 = rx_cnt; tk0 = take_cnt; pr0 = pull_rises;
        tx_arm = 1'b1; tx_bit = 1'b0;
        wait_cyc(300 * CPU);
        tx_arm = 1'b0;
        chk(pull_rises == pr0 + 1, "R9 presence occurred", pull_rises - pr0, 1);
        chk(take_cnt == tk0, "R9 no take from own edge", take_cnt - tk0, 0);
        chk(rx_cnt == rx0, "R9 no rx from own edge", rx_cnt - rx0, 0);

        // R3 after presence: engine is back to normal slots
        rx0 = rx_cnt;
        slot(5 * CPU, 75 * CPU);
        chk(rx_cnt == rx0 + 1 && last_rx_bit == 1, "R3 slot after presence",
            last_rx_bit, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule